// File: doc/BRIEF.md
# Spreading-Code Correlation Detector

This block watches a direct-sequence spread-spectrum sample stream for the moment it lines up with a known spreading code. Signed in-phase and quadrature samples arrive with a qualifying strobe. Each channel passes through its own sample delay line of code length. Every tap either adds or subtracts its delayed sample, as the matching code chip is +1 or −1, so the datapath holds no multiplier. The tap weights run in the reverse order of the code. The sum therefore peaks when the most recent samples match the code chips in arrival order.

The two channel sums are combined into the approximate magnitude |I|+|Q|. This value is compared with a programmable threshold. When the magnitude is strictly above the threshold, a single-cycle detection pulse marks acquisition. The code is loaded either as a full word or one chip at a time, while no samples are flowing. The code length and the sample width are parameters. The sum width is derived from them so that a full-scale input can never wrap.

Top module: `pn_corr_detector`

## Requirements
- R1: While `rst_n` is low, `corr_i`, `corr_q` and `hit` are zero, every delay slot holds zero, the stored code is all zeros (every chip −1) and the threshold is zero.
- R2: At the rising edge that samples `s_valid` high, `corr_i` takes the value sum over j of x_j·w_j. Here x_0..x_{CODE_LEN-1} are the last CODE_LEN accepted I samples in arrival order, with x_0 the oldest and slots not yet filled since reset counting as zero. The weight w_j is +1 when code bit j is 1 and −1 when it is 0. Code bit 0 is the first chip of the code.
- R3: The sums are AW = SW+clog2(CODE_LEN)+1 bits signed. CODE_LEN full-scale samples of either sign yield the exact sum without wrapping.
- R4: `corr_q` is formed from the Q samples with the same code and the same rule as `corr_i`. Each channel is independent of the other channel's data.
- R5: `hit` is high for exactly the cycle after a valid edge at which |corr_i|+|corr_q| (of the new sums) is strictly greater than the threshold held before that edge. It is low in every other cycle, and a magnitude equal to the threshold does not raise it.
- R6: `hit` stays low for the first CODE_LEN−1 accepted samples after reset. It can rise from the CODE_LEN-th accepted sample onward.
- R7: A cycle with `code_ld` high replaces the whole code with `code_par` (bit j = chip j). The new code applies from the next accepted sample.
- R8: A cycle with `code_sh` high and `code_ld` low shifts `code_sbit` into code bit CODE_LEN−1 and moves every bit down by one. After CODE_LEN shifts, the first bit shifted in is chip 0. `code_ld` has priority over `code_sh`.
- R9: Cycles with `s_valid` low leave the delay lines and both sums unchanged, whatever is on `s_i` and `s_q`.
- R10: A cycle with `thr_we` high loads `thr_in` into the unsigned AW-bit threshold. Otherwise the threshold holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Sample strobe |
| s_i | input | SW | In-phase sample, signed |
| s_q | input | SW | Quadrature sample, signed |
| code_ld | input | 1 | Load the whole code from `code_par` |
| code_par | input | CODE_LEN | Code word, bit j = chip j (1 = +1, 0 = −1) |
| code_sh | input | 1 | Shift one chip into the code |
| code_sbit | input | 1 | Chip value for serial loading |
| thr_we | input | 1 | Threshold write enable |
| thr_in | input | AW | Threshold value, unsigned |
| corr_i | output | AW | In-phase correlation sum, signed |
| corr_q | output | AW | Quadrature correlation sum, signed |
| hit | output | 1 | One-cycle detection pulse |

## Verification
The bench builds the detector with CODE_LEN = 7 and SW = 6, so AW is 10. A short code makes the fill phase, the exact-threshold boundary and the code-aligned peak reachable within a few samples. A 6-bit sample lets full-scale inputs of −32 on all taps drive the widest sum that the derived width must hold. Both load paths are exercised with asymmetric codes, so a reversed tap order or a wrong shift direction changes the expected sums.

// File: rtl/pn_corr_pkg.sv
package pn_corr_pkg;

  // Signed sum width that holds CODE_LEN full-scale samples with no wrap.
  function automatic int unsigned sum_width(int unsigned code_len, int unsigned sw);
    return sw + $clog2(code_len) + 1;
  endfunction

  localparam int unsigned NUM_CH = 2;

endpackage

// File: rtl/pn_code_reg.sv
module pn_code_reg #(
  parameter int unsigned CODE_LEN = 25
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                par_ld,
  input  logic [CODE_LEN-1:0] par_val,
  input  logic                ser_sh,
  input  logic                ser_bit,
  output logic [CODE_LEN-1:0] code
);

  logic [CODE_LEN-1:0] code_d;
  logic                code_en;

  always_comb begin
    code_en = par_ld | ser_sh;
    if (par_ld) begin
      code_d = par_val;
    end else begin
      code_d = {ser_bit, code[CODE_LEN-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code <= '0;
    end else if (code_en) begin
      code <= code_d;
    end
  end

endmodule

// File: rtl/pn_tap_line.sv
module pn_tap_line #(
  parameter int unsigned CODE_LEN = 25,
  parameter int unsigned SW       = 8,
  parameter int unsigned AW       = 14
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic signed [SW-1:0] din,
  input  logic [CODE_LEN-1:0]  coef,     // coef[k] weights slot k, slot 0 newest
  output logic signed [AW-1:0] sum_nxt,
  output logic signed [AW-1:0] sum_q
);

  logic signed [SW-1:0] slot_q [CODE_LEN];
  logic signed [SW-1:0] slot_d [CODE_LEN];
  logic signed [AW-1:0] term   [CODE_LEN];

  always_comb begin
    for (int k = 0; k < CODE_LEN; k++) slot_d[k] = slot_q[k];
    if (en) begin
      slot_d[0] = din;
      for (int k = 1; k < CODE_LEN; k++) slot_d[k] = slot_q[k-1];
    end
  end

  for (genvar k = 0; k < CODE_LEN; k++) begin : g_tap
    logic signed [AW-1:0] ext;
    assign ext     = AW'(slot_d[k]);
    assign term[k] = coef[k] ? ext : -ext;
  end

  always_comb begin
    logic signed [AW-1:0] acc;
    acc = '0;
    for (int k = 0; k < CODE_LEN; k++) acc = acc + term[k];
    sum_nxt = acc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < CODE_LEN; k++) slot_q[k] <= '0;
      sum_q <= '0;
    end else if (en) begin
      for (int k = 0; k < CODE_LEN; k++) slot_q[k] <= slot_d[k];
      sum_q <= sum_nxt;
    end
  end

endmodule

// File: rtl/pn_mag_cmp.sv
module pn_mag_cmp #(
  parameter int unsigned AW = 14
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 armed,
  input  logic signed [AW-1:0] ci,
  input  logic signed [AW-1:0] cq,
  input  logic [AW-1:0]        thr,
  output logic                 hit
);

  logic [AW-1:0] abs_i, abs_q, mag;
  logic          hit_d;

  always_comb begin
    abs_i = ci[AW-1] ? AW'(-ci) : AW'(ci);
    abs_q = cq[AW-1] ? AW'(-cq) : AW'(cq);
    mag   = abs_i + abs_q;
    hit_d = en & armed & (mag > thr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit <= 1'b0;
    end else begin
      hit <= hit_d;
    end
  end

endmodule

// File: rtl/pn_corr_detector.sv
module pn_corr_detector
  import pn_corr_pkg::*;
#(
  parameter int unsigned CODE_LEN = 25,
  parameter int unsigned SW       = 8,
  parameter int unsigned AW       = sum_width(CODE_LEN, SW)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 s_valid,
  input  logic signed [SW-1:0] s_i,
  input  logic signed [SW-1:0] s_q,
  input  logic                 code_ld,
  input  logic [CODE_LEN-1:0]  code_par,
  input  logic                 code_sh,
  input  logic                 code_sbit,
  input  logic                 thr_we,
  input  logic [AW-1:0]        thr_in,
  output logic signed [AW-1:0] corr_i,
  output logic signed [AW-1:0] corr_q,
  output logic                 hit
);

  localparam int unsigned CW = $clog2(CODE_LEN + 1);

  logic [CODE_LEN-1:0]  code_q;
  logic [CODE_LEN-1:0]  coef;
  logic [AW-1:0]        thr_q, thr_d;
  logic [CW-1:0]        fill_q, fill_d;
  logic                 armed;
  logic signed [SW-1:0] ch_din  [NUM_CH];
  logic signed [AW-1:0] ch_nxt  [NUM_CH];
  logic signed [AW-1:0] ch_sum  [NUM_CH];

  pn_code_reg #(.CODE_LEN(CODE_LEN)) u_code (
    .clk     (clk),
    .rst_n   (rst_n),
    .par_ld  (code_ld),
    .par_val (code_par),
    .ser_sh  (code_sh),
    .ser_bit (code_sbit),
    .code    (code_q)
  );

  // Tap weights are the code in reverse time order: slot k holds the
  // sample that arrived k strobes ago, which aligns with chip CODE_LEN-1-k.
  for (genvar k = 0; k < CODE_LEN; k++) begin : g_rev
    assign coef[k] = code_q[CODE_LEN-1-k];
  end

  assign ch_din[0] = s_i;
  assign ch_din[1] = s_q;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pn_tap_line #(.CODE_LEN(CODE_LEN), .SW(SW), .AW(AW)) u_line (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (s_valid),
      .din     (ch_din[c]),
      .coef    (coef),
      .sum_nxt (ch_nxt[c]),
      .sum_q   (ch_sum[c])
    );
  end

  assign corr_i = ch_sum[0];
  assign corr_q = ch_sum[1];

  always_comb begin
    thr_d  = thr_we ? thr_in : thr_q;
    fill_d = fill_q;
    if (s_valid && (fill_q != CW'(CODE_LEN))) fill_d = fill_q + 1'b1;
    armed  = (fill_q >= CW'(CODE_LEN - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q  <= '0;
      fill_q <= '0;
    end else begin
      thr_q  <= thr_d;
      fill_q <= fill_d;
    end
  end

  pn_mag_cmp #(.AW(AW)) u_cmp (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (s_valid),
    .armed (armed),
    .ci    (ch_nxt[0]),
    .cq    (ch_nxt[1]),
    .thr   (thr_q),
    .hit   (hit)
  );

endmodule

// File: rtl/pn_corr_chk.sv
module pn_corr_chk #(
  parameter int unsigned CODE_LEN = 25,
  parameter int unsigned SW       = 8,
  parameter int unsigned AW       = 14
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 s_valid,
  input logic                 code_ld,
  input logic [CODE_LEN-1:0]  code_par,
  input logic [CODE_LEN-1:0]  code_q,
  input logic                 thr_we,
  input logic [AW-1:0]        thr_in,
  input logic [AW-1:0]        thr_q,
  input logic signed [AW-1:0] corr_i,
  input logic signed [AW-1:0] corr_q,
  input logic                 hit
);

  localparam longint LIMIT = longint'(CODE_LEN) * (longint'(1) << (SW - 1));
  localparam int unsigned VW = $clog2(CODE_LEN + 1);

  logic [VW-1:0] vcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vcnt <= '0;
    end else if (s_valid && (vcnt != VW'(CODE_LEN))) begin
      vcnt <= vcnt + 1'b1;
    end
  end

  function automatic longint absl(input logic signed [AW-1:0] v);
    return (v < 0) ? -longint'(v) : longint'(v);
  endfunction

  p_sum_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (absl(corr_i) <= LIMIT) && (absl(corr_q) <= LIMIT));

  p_hit_after_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> $past(s_valid));

  p_hit_mag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> ((absl(corr_i) + absl(corr_q)) > longint'($past(thr_q))));

  p_fill_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (vcnt == VW'(CODE_LEN)));

  p_par_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    code_ld |=> (code_q == $past(code_par)));

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !s_valid |=> ($stable(corr_i) && $stable(corr_q)));

  p_thr_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    thr_we |=> (thr_q == $past(thr_in)));

  p_thr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !thr_we |=> $stable(thr_q));

endmodule

bind pn_corr_detector pn_corr_chk #(
  .CODE_LEN(CODE_LEN), .SW(SW), .AW(AW)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .s_valid  (s_valid),
  .code_ld  (code_ld),
  .code_par (code_par),
  .code_q   (code_q),
  .thr_we   (thr_we),
  .thr_in   (thr_in),
  .thr_q    (thr_q),
  .corr_i   (corr_i),
  .corr_q   (corr_q),
  .hit      (hit)
);

// File: tb/test_pn_corr_detector.sv
module test_pn_corr_detector;

  localparam int CL = 7;
  localparam int SW = 6;
  localparam int AW = SW + $clog2(CL) + 1;

  typedef struct {
    int    ei;
    int    eq;
    bit    eh;
    string tag;
  } exp_t;

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic                 s_valid;
  logic signed [SW-1:0] s_i, s_q;
  logic                 code_ld, code_sh, code_sbit, thr_we;
  logic [CL-1:0]        code_par;
  logic [AW-1:0]        thr_in;
  logic signed [AW-1:0] corr_i, corr_q;
  logic                 hit;

  pn_corr_detector #(.CODE_LEN(CL), .SW(SW)) i_pn_corr_detector (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_i(s_i), .s_q(s_q),
    .code_ld(code_ld), .code_par(code_par), .code_sh(code_sh),
    .code_sbit(code_sbit), .thr_we(thr_we), .thr_in(thr_in),
    .corr_i(corr_i), .corr_q(corr_q), .hit(hit)
  );

  always #10 clk = ~clk;

  int       n_tests = 0;
  int       n_fail  = 0;
  bit       done    = 0;
  exp_t     sb[$];
  int       hist_i[$];
  int       hist_q[$];
  bit [CL-1:0] m_code;
  int       m_thr;
  int       m_fill;
  int       last_i = 0, last_q = 0;
  string    cur_tag = "R2";
  logic     vflag = 1'b0;

  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic model_reset();
    hist_i.delete();
    hist_q.delete();
    for (int k = 0; k < CL; k++) begin
      hist_i.push_back(0);
      hist_q.push_back(0);
    end
    m_code = '0;
    m_thr  = 0;
    m_fill = 0;
  endtask

  task automatic send(input int i, input int q);
    exp_t e;
    @(negedge clk);
    s_valid = 1'b1;
    s_i = SW'(i);
    s_q = SW'(q);
    void'(hist_i.pop_front());
    void'(hist_q.pop_front());
    hist_i.push_back(i);
    hist_q.push_back(q);
    if (m_fill < CL) m_fill++;
    e.ei = 0;
    e.eq = 0;
    for (int j = 0; j < CL; j++) begin
      e.ei += m_code[j] ? hist_i[j] : -hist_i[j];
      e.eq += m_code[j] ? hist_q[j] : -hist_q[j];
    end
    e.eh  = (m_fill >= CL) && ((iabs(e.ei) + iabs(e.eq)) > m_thr);
    e.tag = cur_tag;
    sb.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      s_valid = 1'b0;
      s_i = SW'($urandom);
      s_q = SW'($urandom);
    end
  endtask

  task automatic set_thr(input int t);
    idle(1);
    thr_we = 1'b1;
    thr_in = AW'(t);
    @(negedge clk);
    thr_we = 1'b0;
    m_thr = t;
  endtask

  task automatic load_par(input bit [CL-1:0] c);
    idle(1);
    code_ld  = 1'b1;
    code_par = c;
    @(negedge clk);
    code_ld = 1'b0;
    m_code  = c;
  endtask

  task automatic load_ser(input bit [CL-1:0] c);
    idle(1);
    for (int j = 0; j < CL; j++) begin
      code_sh   = 1'b1;
      code_sbit = c[j];
      @(negedge clk);
    end
    code_sh = 1'b0;
    m_code  = c;
  endtask

  task automatic send_aligned(input int amp, input int qv);
    for (int j = 0; j < CL; j++) send(m_code[j] ? amp : -amp, qv);
  endtask

  // Monitor: one result per accepted sample, idle cycles must hold.
  always @(posedge clk) vflag <= rst_n & s_valid;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (vflag) begin
        if (sb.size() == 0) begin
          check(1'b0, "R2 scoreboard empty", 0, 1);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(int'(corr_i) == e.ei, {e.tag, " corr_i"}, int'(corr_i), e.ei);
          check(int'(corr_q) == e.eq, {e.tag, " corr_q R4"}, int'(corr_q), e.eq);
          check(hit == e.eh, {e.tag, " hit R5"}, int'(hit), int'(e.eh));
          last_i = e.ei;
          last_q = e.eq;
        end
      end else begin
        check(hit == 1'b0, "R5 hit without strobe", int'(hit), 0);
        check(int'(corr_i) == last_i, "R9 corr_i hold", int'(corr_i), last_i);
        check(int'(corr_q) == last_q, "R9 corr_q hold", int'(corr_q), last_q);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    s_valid = 1'b0; s_i = '0; s_q = '0;
    code_ld = 1'b0; code_par = '0; code_sh = 1'b0; code_sbit = 1'b0;
    thr_we = 1'b0; thr_in = '0;
    model_reset();
    repeat (3) @(negedge clk);
    check(corr_i == '0, "R1 corr_i reset", int'(corr_i), 0);
    check(corr_q == '0, "R1 corr_q reset", int'(corr_q), 0);
    check(hit == 1'b0, "R1 hit reset", int'(hit), 0);
    rst_n = 1'b1;

    // R1 / R6: reset contents are zero, fill phase suppresses the pulse
    cur_tag = "R6";
    for (int k = 0; k < CL + 2; k++) send(20 - 3 * k, 5 + k);
    idle(2);

    // R7 / R2: parallel load, code-aligned peak just above threshold
    load_par(7'b1011001);
    set_thr(10 * CL - 1);
    cur_tag = "R7";
    send_aligned(10, 0);
    idle(3);

    // R5: magnitude equal to threshold gives no pulse
    set_thr(10 * CL);
    cur_tag = "R5";
    send_aligned(10, 0);
    idle(2);

    // R3: full-scale negative samples on both channels
    load_par('0);
    set_thr(2 * 32 * CL - 1);
    cur_tag = "R3";
    for (int k = 0; k < CL; k++) send(-32, -32);
    idle(2);
    load_par('1);
    cur_tag = "R3";
    for (int k = 0; k < CL; k++) send(31, -32);
    idle(2);

    // R8: serial load of an asymmetric code
    load_ser(7'b0010111);
    set_thr(60);
    cur_tag = "R8";
    send_aligned(9, 0);
    idle(2);

    // R4: aligned I with unrelated Q data
    cur_tag = "R4";
    for (int j = 0; j < CL; j++) send(m_code[j] ? 12 : -12, (j * 7) % 13 - 6);
    idle(2);

    // R9 / R10: random stream with idle gaps, threshold changes
    set_thr(90);
    cur_tag = "R9";
    for (int k = 0; k < 60; k++) begin
      send($signed(SW'($urandom)), $signed(SW'($urandom)));
      if (k % 5 == 2) idle(1 + (k % 3));
      if (k == 30) begin
        set_thr(40);
        cur_tag = "R10";
      end
    end
    idle(4);
    check(sb.size() == 0, "R2 results outstanding", sb.size(), 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule